// File: doc/BRIEF.md
# Interrupt Register Shadow Stack

This block keeps a private hardware stack for each architectural register of a small processor core, so that interrupt entry and return need no memory traffic for register saving. When the core takes an interrupt it raises one strobe, and the current value of every register is written into that register's own stack in the same clock edge. When the core returns from the interrupt it raises the other strobe, and one edge later the most recently saved set of values is presented for reload. Software has no way to read or write these stacks.

All lanes share one stack pointer, so every lane always holds the same number of saved entries. The block can therefore track nested, re-entrant interrupts up to a fixed depth. The depth is set by a parameter, typically 8 or 16. Exceeding the depth in either direction is defined behaviour:
- An extra save is refused and raises a sticky overflow flag.
- A restore with nothing saved returns all zeros and raises a sticky underflow flag.

A save and a restore requested in the same cycle act as a restore followed by a save. The saved set on top is handed out and then replaced, and the nesting level does not change. A level output reports the current nesting depth.

Top module: `irq_shadow_stack`

## Requirements
- R1: After reset, level_o is 0, overflow_o and underflow_o are 0, restore_valid_o is 0 and regs_o is all zeros.
- R2: A cycle with save_i high and restore_i low, taken while level_o is below DEPTH, stores the whole of regs_i and raises level_o by one after that edge.
- R3: A cycle with restore_i high makes restore_valid_o high for exactly the next cycle. If level_o was nonzero, regs_o then shows the most recently saved set that has not yet been restored, and when save_i was low level_o drops by one. regs_o holds its value until the next restore. restore_valid_o is low after any cycle without restore_i.
- R4: A save alone while level_o equals DEPTH is refused. level_o stays at DEPTH, overflow_o becomes 1, and the saved contents are unchanged, which later restores show.
- R5: overflow_o and underflow_o, once set, stay set until reset, regardless of any later save or restore.
- R6: A restore alone while level_o is 0 gives regs_o equal to zero, sets underflow_o and leaves level_o at 0.
- R7: save_i and restore_i together while level_o is nonzero output the top set on regs_o, replace the top set with regs_i and leave level_o unchanged. This applies even at level DEPTH, where it does not set overflow_o.
- R8: save_i and restore_i together while level_o is 0 give regs_o equal to zero, set underflow_o, and store regs_i so that level_o becomes 1.
- R9: level_o always equals the number of saved sets and never exceeds DEPTH.
- R10: Register k occupies bits [k*DATA_W +: DATA_W] of both regs_i and regs_o, and each lane restores exactly the value saved for it, independently of the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_i | input | 1 | Interrupt entry strobe: save all register values |
| restore_i | input | 1 | Interrupt return strobe: restore all register values |
| regs_i | input | NUM_REGS*DATA_W | Current register values, lane k at bits [k*DATA_W +: DATA_W] |
| regs_o | output | NUM_REGS*DATA_W | Restored register values, same lane layout |
| restore_valid_o | output | 1 | High for the cycle after a restore request |
| overflow_o | output | 1 | Sticky: a save was refused because the stacks were full |
| underflow_o | output | 1 | Sticky: a restore was requested with nothing saved |
| level_o | output | $clog2(DEPTH+1) | Current nesting level |

## Verification
The save and restore strobes are driven in four combinations:
- A lone save or a lone restore shows plain last-in first-out order.
- Both strobes together separate a replace-top from a separate pop and push.
- The same combined request at level zero and at full depth exposes the edge handling of each.

Every lane is loaded with a different value pattern in each cycle, so a swapped or shared lane appears on restore. Filling to depth, overfilling, and then draining shows whether a refused save corrupted stored data. A restore at level zero after the flags are set checks that zeros are returned and that the flags stay sticky.

// File: rtl/shstk_pkg.sv
package shstk_pkg;

  // Combined request seen by the pointer control in one cycle.
  typedef enum logic [1:0] {
    REQ_NONE    = 2'b00,
    REQ_SAVE    = 2'b01,
    REQ_RESTORE = 2'b10,
    REQ_SWAP    = 2'b11
  } shstk_req_e;

  function automatic shstk_req_e decode_req(input logic save, input logic restore);
    return shstk_req_e'({restore, save});
  endfunction

endpackage

// File: rtl/shstk_ctrl.sv
module shstk_ctrl
  import shstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_i,
  input  logic             restore_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic             rd_en_o,
  output logic             rd_zero_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic [LVL_W-1:0] level_o,
  output logic             overflow_o,
  output logic             underflow_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             push_reject_o,
  output logic             pop_reject_o
);

  logic [LVL_W-1:0] level_q;
  logic             ovf_q;
  logic             unf_q;
  logic             empty;
  logic             full;
  shstk_req_e       req;

  // Level after one accepted push and/or pop.
  function automatic logic [LVL_W-1:0] next_level(input logic [LVL_W-1:0] cur,
                                                  input logic inc, input logic dec);
    logic [LVL_W-1:0] r;
    r = cur;
    if (inc && !dec) r = cur + LVL_W'(1);
    if (dec && !inc) r = cur - LVL_W'(1);
    return r;
  endfunction

  function automatic logic [PTR_W-1:0] top_index(input logic [LVL_W-1:0] cur);
    logic [LVL_W-1:0] t;
    t = cur - LVL_W'(1);
    return t[PTR_W-1:0];
  endfunction

  assign empty = (level_q == '0);
  assign full  = (level_q == LVL_W'(DEPTH));
  assign req   = decode_req(save_i, restore_i);

  always_comb begin
    pop_ok_o      = 1'b0;
    pop_reject_o  = 1'b0;
    push_ok_o     = 1'b0;
    push_reject_o = 1'b0;
    unique case (req)
      REQ_SAVE: begin
        push_ok_o     = !full;
        push_reject_o = full;
      end
      REQ_RESTORE: begin
        pop_ok_o     = !empty;
        pop_reject_o = empty;
      end
      REQ_SWAP: begin
        // pop first, then push: a successful pop always frees a slot
        pop_ok_o     = !empty;
        pop_reject_o = empty;
        push_ok_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign wr_en_o   = push_ok_o;
  assign wr_idx_o  = pop_ok_o ? top_index(level_q) : level_q[PTR_W-1:0];
  assign rd_en_o   = restore_i;
  assign rd_zero_o = pop_reject_o;
  assign rd_idx_o  = top_index(level_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      level_q <= next_level(level_q, push_ok_o, pop_ok_o);
      if (push_reject_o) ovf_q <= 1'b1;
      if (pop_reject_o)  unf_q <= 1'b1;
    end
  end

  assign level_o     = level_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

endmodule

// File: rtl/shstk_lane.sv
module shstk_lane #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_zero_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] out_q;

  // Storage: contents are only observable through a pop, so no reset.
  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
  end

  // Read happens before the write of the same edge (pop-then-push order).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (rd_en_i) begin
      out_q <= rd_zero_i ? '0 : mem[rd_idx_i];
    end
  end

  assign rd_data_o = out_q;

endmodule

// File: rtl/irq_shadow_stack.sv
module irq_shadow_stack #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 8,
  localparam int WORD_W  = NUM_REGS * DATA_W,
  localparam int LVL_W   = $clog2(DEPTH + 1),
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic [WORD_W-1:0] regs_i,
  output logic [WORD_W-1:0] regs_o,
  output logic              restore_valid_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic [LVL_W-1:0]  level_o
);

  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic             rd_en;
  logic             rd_zero;
  logic [PTR_W-1:0] rd_idx;
  // named internal events, used by the bound checker
  logic             push_ok;
  logic             pop_ok;
  logic             push_reject;
  logic             pop_reject;
  logic             valid_q;

  shstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .save_i        (save_i),
    .restore_i     (restore_i),
    .wr_en_o       (wr_en),
    .wr_idx_o      (wr_idx),
    .rd_en_o       (rd_en),
    .rd_zero_o     (rd_zero),
    .rd_idx_o      (rd_idx),
    .level_o       (level_o),
    .overflow_o    (overflow_o),
    .underflow_o   (underflow_o),
    .push_ok_o     (push_ok),
    .pop_ok_o      (pop_ok),
    .push_reject_o (push_reject),
    .pop_reject_o  (pop_reject)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_lane
    shstk_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (regs_i[k*DATA_W +: DATA_W]),
      .rd_en_i   (rd_en),
      .rd_zero_i (rd_zero),
      .rd_idx_i  (rd_idx),
      .rd_data_o (regs_o[k*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= restore_i;
  end

  assign restore_valid_o = valid_q;

endmodule

// File: rtl/irq_shadow_stack_checks.sv
module irq_shadow_stack_checks #(
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 4,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restore_i,
  input logic [WORD_W-1:0] regs_o,
  input logic              restore_valid_o,
  input logic              overflow_o,
  input logic              underflow_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              push_ok,
  input logic              pop_ok,
  input logic              push_reject,
  input logic              pop_reject
);

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (level_o == $past(level_o) + LVL_W'(1)));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> restore_valid_o);

  a_r3_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !restore_i |=> !restore_valid_o);

  a_r4_refused_save: assert property (@(posedge clk) disable iff (!rst_n)
    (push_reject && !restore_i) |=> ($stable(level_o) && overflow_o));

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  a_r5_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);

  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pop_reject |=> (regs_o == '0 && underflow_o));

  a_r7_swap_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(level_o));

  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LVL_W'(DEPTH));

endmodule

bind irq_shadow_stack irq_shadow_stack_checks #(
  .DEPTH(DEPTH), .LVL_W(LVL_W), .WORD_W(WORD_W)
) u_checks (
  .clk             (clk),
  .rst_n           (rst_n),
  .restore_i       (restore_i),
  .regs_o          (regs_o),
  .restore_valid_o (restore_valid_o),
  .overflow_o      (overflow_o),
  .underflow_o     (underflow_o),
  .level_o         (level_o),
  .push_ok         (push_ok),
  .pop_ok          (pop_ok),
  .push_reject     (push_reject),
  .pop_reject      (pop_reject)
);

// File: tb/irq_shadow_stack_test.sv
module irq_shadow_stack_test;

  localparam int NUM_REGS = 4;
  localparam int DATA_W   = 8;
  localparam int DEPTH    = 8;
  localparam int WORD_W   = NUM_REGS * DATA_W;
  localparam int LVL_W    = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              save_i = 1'b0;
  logic              restore_i = 1'b0;
  logic [WORD_W-1:0] regs_i = '0;
  logic [WORD_W-1:0] regs_o;
  logic              restore_valid_o;
  logic              overflow_o;
  logic              underflow_o;
  logic [LVL_W-1:0]  level_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench-side model of the saved sets
  logic [WORD_W-1:0] m_stk [DEPTH];
  int                m_lvl;
  logic [WORD_W-1:0] m_out;
  bit                m_ovf;
  bit                m_unf;

  irq_shadow_stack #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
    .regs_i(regs_i), .regs_o(regs_o), .restore_valid_o(restore_valid_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o), .level_o(level_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; save_i = 1'b0; restore_i = 1'b0; regs_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_lvl = 0; m_out = '0; m_ovf = 0; m_unf = 0;
    @(negedge clk);
  endtask

  // Distinct value in every lane, derived from a seed.
  function automatic logic [WORD_W-1:0] pattern(input int seed);
    logic [WORD_W-1:0] w;
    for (int k = 0; k < NUM_REGS; k++)
      w[k*DATA_W +: DATA_W] = DATA_W'(seed * 16 + k * 3 + 1);
    return w;
  endfunction

  // One cycle of stimulus; expectation follows the requirements, then check.
  task automatic step(input string tag, input bit sv, input bit rs,
                      input logic [WORD_W-1:0] data);
    save_i = sv; restore_i = rs; regs_i = data;
    if (rs) begin
      if (m_lvl == 0) begin
        m_out = '0; m_unf = 1;
        if (sv) begin m_stk[0] = data; m_lvl = 1; end
      end else begin
        m_out = m_stk[m_lvl-1];
        if (sv) m_stk[m_lvl-1] = data;
        else    m_lvl--;
      end
    end else if (sv) begin
      if (m_lvl == DEPTH) m_ovf = 1;
      else begin m_stk[m_lvl] = data; m_lvl++; end
    end
    @(negedge clk);
    save_i = 1'b0; restore_i = 1'b0;
    check(tag, "regs_o", regs_o, m_out);
    check(tag, "restore_valid_o", WORD_W'(restore_valid_o), WORD_W'(rs));
    check(tag, "level_o", WORD_W'(level_o), WORD_W'(m_lvl));
    check(tag, "overflow_o", WORD_W'(overflow_o), WORD_W'(m_ovf));
    check(tag, "underflow_o", WORD_W'(underflow_o), WORD_W'(m_unf));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "regs_o", regs_o, '0);
    check("R1", "level_o", WORD_W'(level_o), '0);
    check("R1", "flags", WORD_W'({overflow_o, underflow_o, restore_valid_o}), '0);
  endtask

  task automatic t_lifo();
    do_reset();
    step("R2", 1, 0, pattern(1));
    step("R2", 1, 0, pattern(2));
    step("R10", 1, 0, 32'hA55A_0FF0);
    step("R10", 0, 1, '0);
    step("R3", 0, 0, '0);   // output held, valid back low
    step("R3", 0, 1, '0);
    step("R3", 0, 1, '0);
  endtask

  task automatic t_fill_overflow();
    do_reset();
    for (int i = 0; i < DEPTH; i++) step("R9", 1, 0, pattern(i + 5));
    step("R4", 1, 0, 32'hDEAD_BEEF);
    step("R4", 1, 0, 32'h1234_5678);
    for (int i = 0; i < DEPTH; i++) step("R4", 0, 1, '0);
    step("R5", 0, 0, '0);
  endtask

  task automatic t_empty_pop();
    do_reset();
    step("R6", 0, 1, '0);
    step("R5", 1, 0, pattern(9));
    step("R5", 0, 1, '0);
    step("R6", 0, 1, '0);
  endtask

  task automatic t_swap();
    do_reset();
    step("R7", 1, 0, pattern(3));
    step("R7", 1, 0, pattern(4));
    step("R7", 1, 1, pattern(7));
    step("R7", 0, 1, '0);
    step("R7", 0, 1, '0);
    for (int i = 0; i < DEPTH; i++) step("R7", 1, 0, pattern(i + 20));
    step("R7", 1, 1, 32'hCAFE_F00D);   // at full depth: no overflow
    step("R7", 0, 1, '0);
  endtask

  task automatic t_swap_empty();
    do_reset();
    step("R8", 1, 1, 32'h0BAD_C0DE);
    step("R8", 0, 1, '0);
    step("R8", 0, 0, '0);
  endtask

  initial begin
    t_reset();
    t_lifo();
    t_fill_overflow();
    t_empty_pop();
    t_swap();
    t_swap_empty();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule